// File: doc/BRIEF.md
# Asynchronous Static Memory Read Sequencer

This block runs read cycles on one chip select of an external asynchronous static memory. A host raises a request with a byte address. The block takes the request, drives the memory address and the two active-low strobes, chip enable and read enable, and samples the 16-bit data bus. It then hands the word back with a one-clock completion pulse.

Each strobe has its own programmable timing, counted in clocks. The setup count is the number of clocks before the strobe goes low, and the pulse count is the number of clocks it stays low. Both strobes share one total cycle length. The block never compares the two waveforms with each other. A single selection bit decides whose rising edge samples the data. All timing fields, the selection bit and the address are latched when a request is accepted. Changes made while a cycle runs therefore apply only to the next cycle.

Clock index k counts the clocks of a cycle. Index 0 is the clock that follows the accepting edge.

Top module: `srd_seq`

## Requirements
- R1: `mem_rd_n` is low exactly in clocks k with rd_setup <= k < rd_setup + rd_pulse and k < cycle length. It does not depend on the chip-enable settings.
- R2: `mem_cs_n` is low exactly in clocks k with cs_setup <= k < cs_setup + cs_pulse and k < cycle length, using its own settings only.
- R3: A pulse value of 0 behaves as 1, and a cycle value of 0 behaves as 1.
- R4: Both strobes are high whenever the block is idle. A strobe whose setup plus pulse exceeds the cycle length rises at the end of the cycle.
- R5: With `cfg_rd_ctrl`=1, data is sampled on the edge that raises `mem_rd_n`. With `cfg_rd_ctrl`=0, it is sampled on the edge that raises `mem_cs_n`. If the selected strobe never goes low, data is sampled on the edge that ends the cycle. Exactly one sample is taken per cycle.
- R6: `done` is high for exactly one clock, the clock right after the sampling edge. `rdata` keeps the sampled word until the next sample.
- R7: `busy` is high for exactly cycle-length clocks, starting at k=0. A request is accepted only while `busy` is low. A request held high through a cycle therefore restarts after exactly one idle clock.
- R8: `mem_addr` equals the accepted `addr[ADDR_W-1:2]` and `mem_lo` equals the accepted `addr[1:0]`. Both are stable for the whole cycle, even if `addr` changes.
- R9: Timing fields and `cfg_rd_ctrl` are sampled at acceptance. Changing them during a cycle does not alter that cycle.
- R10: While `rst` is high, `busy` and `done` are 0, both strobes are 1 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request |
| addr | input | ADDR_W | Byte address of the read |
| cfg_cs_setup | input | CNT_W | Chip-enable setup, clocks |
| cfg_cs_pulse | input | CNT_W | Chip-enable low width, clocks |
| cfg_rd_setup | input | CNT_W | Read-enable setup, clocks |
| cfg_rd_pulse | input | CNT_W | Read-enable low width, clocks |
| cfg_cycle | input | CNT_W | Total cycle length, clocks |
| cfg_rd_ctrl | input | 1 | 1: read enable times the sample; 0: chip enable |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Sampled read word |
| mem_addr | output | ADDR_W-2 | Memory address, upper bits |
| mem_lo | output | 2 | Low address lines |
| mem_cs_n | output | 1 | Active-low chip enable |
| mem_rd_n | output | 1 | Active-low read enable |
| mem_data | input | DATA_W | Memory data bus |

## Verification
Two events can land on the same clock edge: the data sample and the end of the cycle. This happens when the selected strobe's setup plus pulse reaches or passes the cycle length, or when its setup alone does. The bench sets up each of these cases: an exact fit, an overflow, and a strobe that never asserts. It changes the data bus on every clock, so the word found in `rdata` identifies the edge that sampled it. A single sample is confirmed by `done` appearing in exactly one clock, the clock after the cycle ends.

// File: rtl/srd_pkg.sv
package srd_pkg;

    localparam int CNT_W = 6;
    localparam int SUM_W = CNT_W + 1;
    localparam int NSTB  = 2;
    localparam int STB_CS = 0;
    localparam int STB_RD = 1;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [SUM_W-1:0] sum_t;

    typedef enum logic {
        CAP_CS = 1'b0,
        CAP_RD = 1'b1
    } cap_sel_e;

    typedef struct packed {
        cnt_t setup;
        cnt_t pulse;
    } stb_cfg_t;

    function automatic cnt_t at_least_one(cnt_t v);
        return (v == '0) ? cnt_t'(1) : v;
    endfunction

endpackage

// File: rtl/srd_timer.sv
module srd_timer
    import srd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  cnt_t cycle_in,
    output logic start,
    output logic busy,
    output cnt_t cnt,
    output logic last
);

    logic busy_q;
    cnt_t cnt_q;
    cnt_t cycle_q;

    assign start = req && !busy_q;
    assign busy  = busy_q;
    assign cnt   = cnt_q;
    assign last  = busy_q && (cnt_q == cycle_q - cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            cycle_q <= cnt_t'(1);
        end else if (start) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            cycle_q <= at_least_one(cycle_in);
        end else if (busy_q) begin
            if (last) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + cnt_t'(1);
            end
        end
    end

    // R3: a latched cycle length is never zero while running
    assert_cycle_legal_R3: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cycle_q != '0));

endmodule

// File: rtl/srd_strobe.sv
module srd_strobe
    import srd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     busy,
    input  cnt_t     cnt,
    input  logic     last,
    input  stb_cfg_t cfg,
    output logic     low,
    output logic     rise
);

    sum_t cnt_w;
    sum_t set_w;
    sum_t end_w;

    assign cnt_w = {1'b0, cnt};
    assign set_w = {1'b0, cfg.setup};
    assign end_w = set_w + {1'b0, cfg.pulse};

    assign low  = busy && (cnt_w >= set_w) && (cnt_w < end_w);
    assign rise = low && ((cnt_w == end_w - sum_t'(1)) || last);

    // R3: the latched pulse width is never zero during a cycle
    assert_pulse_legal_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cfg.pulse != '0));

endmodule

// File: rtl/srd_capture.sv
module srd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              last,
    input  logic              rise,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    logic taken_q;
    logic cap;

    assign cap = busy && !taken_q && (rise || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            taken_q <= (busy && !last) ? (taken_q | cap) : 1'b0;
            done    <= cap;
            if (cap) begin
                rdata <= mem_data;
            end
        end
    end

    // R6: the word stays put unless a completion pulse announces a new one
    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rdata));

endmodule

// File: rtl/srd_seq.sv
module srd_seq
    import srd_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cfg_cs_setup,
    input  logic [CNT_W-1:0]  cfg_cs_pulse,
    input  logic [CNT_W-1:0]  cfg_rd_setup,
    input  logic [CNT_W-1:0]  cfg_rd_pulse,
    input  logic [CNT_W-1:0]  cfg_cycle,
    input  logic              cfg_rd_ctrl,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [1:0]        mem_lo,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    input  logic [DATA_W-1:0] mem_data
);

    logic              start;
    logic              busy_i;
    cnt_t              cnt;
    logic              last;
    logic [NSTB-1:0]   low;
    logic [NSTB-1:0]   rise;
    logic              rise_sel;
    stb_cfg_t          cfg_q [NSTB];
    cap_sel_e          mode_q;
    logic [ADDR_W-1:0] addr_q;

    srd_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .cycle_in (cfg_cycle),
        .start    (start),
        .busy     (busy_i),
        .cnt      (cnt),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSTB; i++) begin
                cfg_q[i] <= '{setup: '0, pulse: cnt_t'(1)};
            end
            mode_q <= CAP_RD;
            addr_q <= '0;
        end else if (start) begin
            cfg_q[STB_CS] <= '{setup: cfg_cs_setup, pulse: at_least_one(cfg_cs_pulse)};
            cfg_q[STB_RD] <= '{setup: cfg_rd_setup, pulse: at_least_one(cfg_rd_pulse)};
            mode_q        <= cap_sel_e'(cfg_rd_ctrl);
            addr_q        <= addr;
        end
    end

    for (genvar g = 0; g < NSTB; g++) begin : g_stb
        srd_strobe u_stb (
            .clk  (clk),
            .rst  (rst),
            .busy (busy_i),
            .cnt  (cnt),
            .last (last),
            .cfg  (cfg_q[g]),
            .low  (low[g]),
            .rise (rise[g])
        );
    end

    assign rise_sel = (mode_q == CAP_RD) ? rise[STB_RD] : rise[STB_CS];

    srd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy_i),
        .last     (last),
        .rise     (rise_sel),
        .mem_data (mem_data),
        .rdata    (rdata),
        .done     (done)
    );

    assign busy     = busy_i;
    assign mem_cs_n = ~low[STB_CS];
    assign mem_rd_n = ~low[STB_RD];
    assign mem_addr = addr_q[ADDR_W-1:2];
    assign mem_lo   = addr_q[1:0];

    assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
        !busy_i |-> (mem_cs_n && mem_rd_n));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_from_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy_i));

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_i && $past(busy_i)) |-> ($stable(mem_addr) && $stable(mem_lo)));

    // R5: a rising edge of the selected strobe comes with the completion pulse
    assert_rise_samples_R5: assert property (@(posedge clk) disable iff (rst)
        $rose((mode_q == CAP_RD) ? mem_rd_n : mem_cs_n) |-> done);

endmodule

// File: tb/test_srd_seq.sv
module test_srd_seq;
    import srd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 26;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic [5:0]  cs_s;
        logic [5:0]  cs_p;
        logic [5:0]  rd_s;
        logic [5:0]  rd_p;
        logic [5:0]  cyc;
        logic        mode;
        logic [25:0] adr;
        logic [15:0] base;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{6'd0, 6'd4, 6'd1, 6'd2, 6'd5, 1'b1, 26'h0123457, 16'h1000},
        '{6'd0, 6'd4, 6'd1, 6'd2, 6'd5, 1'b0, 26'h2ABCDE1, 16'h2000},
        '{6'd0, 6'd2, 6'd2, 6'd5, 6'd4, 1'b1, 26'h0000002, 16'h3000},
        '{6'd0, 6'd0, 6'd0, 6'd3, 6'd6, 1'b0, 26'h3FFFFFF, 16'h4000},
        '{6'd1, 6'd1, 6'd7, 6'd2, 6'd4, 1'b1, 26'h1111113, 16'h5000},
        '{6'd1, 6'd1, 6'd0, 6'd6, 6'd6, 1'b1, 26'h0F0F0F0, 16'h6000},
        '{6'd0, 6'd1, 6'd0, 6'd1, 6'd0, 1'b1, 26'h0000001, 16'h7000},
        '{6'd2, 6'd3, 6'd3, 6'd1, 6'd8, 1'b0, 26'h1234560, 16'h8000}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              req;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cfg_cs_setup, cfg_cs_pulse, cfg_rd_setup, cfg_rd_pulse, cfg_cycle;
    logic              cfg_rd_ctrl;
    logic              busy, done;
    logic [DATA_W-1:0] rdata;
    logic [ADDR_W-3:0] mem_addr;
    logic [1:0]        mem_lo;
    logic              mem_cs_n, mem_rd_n;
    logic [DATA_W-1:0] mem_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_srd_seq (
        .clk(clk), .rst(rst), .req(req), .addr(addr),
        .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_pulse(cfg_rd_pulse),
        .cfg_cycle(cfg_cycle), .cfg_rd_ctrl(cfg_rd_ctrl),
        .busy(busy), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_lo(mem_lo),
        .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_data(mem_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic bit exp_low(int s, int p, int c, int k);
        return (k < eff(c)) && (k >= s) && (k < s + eff(p));
    endfunction

    function automatic int exp_cap(int s, int p, int c);
        int e;
        if (s >= eff(c)) return eff(c) - 1;
        e = s + eff(p);
        return ((e < eff(c)) ? e : eff(c)) - 1;
    endfunction

    task automatic run_vec(input vec_t v);
        int cc, ck;
        cc = eff(int'(v.cyc));
        ck = v.mode ? exp_cap(int'(v.rd_s), int'(v.rd_p), int'(v.cyc))
                    : exp_cap(int'(v.cs_s), int'(v.cs_p), int'(v.cyc));
        @(negedge clk);
        cfg_cs_setup = v.cs_s; cfg_cs_pulse = v.cs_p;
        cfg_rd_setup = v.rd_s; cfg_rd_pulse = v.rd_p;
        cfg_cycle = v.cyc; cfg_rd_ctrl = v.mode;
        addr = v.adr; req = 1'b1; mem_data = v.base;
        for (int k = 0; k < cc + 3; k++) begin
            @(negedge clk);
            if (k == 0) begin
                req = 1'b0;
                // R9: scramble settings and address mid-cycle
                cfg_cs_setup = ~v.cs_s; cfg_cs_pulse = ~v.cs_p;
                cfg_rd_setup = ~v.rd_s; cfg_rd_pulse = ~v.rd_p;
                cfg_cycle = ~v.cyc; cfg_rd_ctrl = ~v.mode; addr = ~v.adr;
            end
            mem_data = v.base + DATA_W'(k);
            chk(busy == (k < cc), "R7 busy", busy, (k < cc));
            chk(mem_rd_n == !exp_low(int'(v.rd_s), int'(v.rd_p), int'(v.cyc), k),
                "R1 R3 R4 R9 rd strobe", mem_rd_n,
                !exp_low(int'(v.rd_s), int'(v.rd_p), int'(v.cyc), k));
            chk(mem_cs_n == !exp_low(int'(v.cs_s), int'(v.cs_p), int'(v.cyc), k),
                "R2 R3 R4 R9 cs strobe", mem_cs_n,
                !exp_low(int'(v.cs_s), int'(v.cs_p), int'(v.cyc), k));
            chk(done == (k == ck + 1), "R6 done timing", done, (k == ck + 1));
            if (k < cc) begin
                chk({mem_addr, mem_lo} == v.adr, "R8 address", {mem_addr, mem_lo}, v.adr);
            end
        end
        chk(rdata == v.base + DATA_W'(ck), "R5 R6 sampled word", rdata, v.base + DATA_W'(ck));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req = 1'b0; addr = '0; mem_data = '0;
        cfg_cs_setup = '0; cfg_cs_pulse = 6'd1; cfg_rd_setup = '0; cfg_rd_pulse = 6'd1;
        cfg_cycle = 6'd1; cfg_rd_ctrl = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0, "R10 busy", busy, 0);
        chk(done == 1'b0, "R10 done", done, 0);
        chk(mem_cs_n && mem_rd_n, "R10 strobes", {mem_cs_n, mem_rd_n}, 2'b11);
        chk(rdata == '0, "R10 rdata", rdata, 0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
        end

        // R7 R8: held request, one idle clock, new address on the second cycle
        @(negedge clk);
        cfg_cs_setup = 6'd0; cfg_cs_pulse = 6'd2; cfg_rd_setup = 6'd0; cfg_rd_pulse = 6'd2;
        cfg_cycle = 6'd3; cfg_rd_ctrl = 1'b1; addr = 26'h0AAAAA8; req = 1'b1;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (k == 0) addr = 26'h1555554;
            if (k == 4) req = 1'b0;
            chk(busy == ((k != 3) && (k < 7)), "R7 held request", busy, ((k != 3) && (k < 7)));
            if (k == 2) chk({mem_addr, mem_lo} == 26'h0AAAAA8, "R8 first address",
                            {mem_addr, mem_lo}, 26'h0AAAAA8);
            if (k == 5) chk({mem_addr, mem_lo} == 26'h1555554, "R8 second address",
                            {mem_addr, mem_lo}, 26'h1555554);
        end

        // R6: rdata holds while idle
        repeat (4) @(negedge clk);
        chk(done == 1'b0, "R6 no stray done", done, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule